// File: doc/BRIEF.md
# SPI Register Command Engine

This block is the protocol engine that sits behind the select-byte router of a serial peripheral link. It serves the on-chip register bank. A byte router upstream has already consumed the select byte. It then lowers `csN` for this engine, which parses what follows: an opcode byte, then an address or a don't-care byte, then a stuffing byte or a data byte, depending on the opcode. From those bytes the engine issues one-cycle write and read strobes to the register bank. During the last byte of a read frame it shifts the returned register value, or a fixed revision code, back out on `miso`.

The serial pins are sampled with the system clock `clk`. They pass through a short synchronizer, and the engine finds the SCLK edges from the synchronized copy. The link runs in mode 0: the engine samples MOSI on the rising edge of SCLK, changes MISO after the falling edge, and sends every field most significant bit first. The register bank answers a read strobe with its data on `regRdData` one clock later. The revision code and the highest valid register address are build-time parameters (`REV_ID`, default 0x3C; `MAX_ADDR`, default 0x19).

Top module: `spi_reg_cmd_engine`

## Requirements
- R1: A frame of opcode 0x01, an address byte A and a data byte D produces exactly one `regWrEn` pulse, one clock long, with `regAddr`=A and `regWrData`=D. The pulse comes a few clocks after the last rising SCLK edge of D.
- R2: A frame of opcode 0x05, an address byte A, a stuffing byte of any value and a fourth byte produces one `regRdEn` pulse with `regAddr`=A after the address byte. The value on `regRdData` one clock after that pulse is shifted out on `miso` during the fourth byte.
- R3: A frame of opcode 0x9F, a byte of any value and a third byte shifts `REV_ID` out on `miso` during the third byte, and produces no strobe.
- R4: MOSI is sampled on rising SCLK. MISO changes only after a falling SCLK edge or while `csN` is high. Every byte is sent MSB first (bit 7 is the first bit on the wire).
- R5: An address above `MAX_ADDR` (0x1A and up) produces no write or read strobe, and a read of such an address returns 0x00. Addresses 0x00 and 0x19 are accepted.
- R6: An opcode other than 0x01, 0x05 and 0x9F produces no strobe, and `miso` stays 0 until `csN` rises.
- R7: Bytes after a frame's last byte are ignored: they cause no further strobe and read back as 0x00. `miso` is 0 during every byte that is not the returned data byte.
- R8: If `csN` rises before all eight bits of a write data byte have arrived, no write strobe is issued.
- R9: A rise of `csN` returns the engine to its idle state. The next low period of `csN` starts again with an opcode byte.
- R10: During reset and right after it, `miso`, `regWrEn` and `regRdEn` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select of this engine from the byte router |
| sclk | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| regWrEn | output | 1 | One-clock register write strobe |
| regRdEn | output | 1 | One-clock register read strobe |
| regAddr | output | 8 | Register address for both strobes |
| regWrData | output | 8 | Register write data |
| regRdData | input | 8 | Register read data, valid one clock after `regRdEn` |

## Verification
Suppose the framing state or the bit counter is wrong inside the engine. Within a few clocks of the affected byte's last rising SCLK edge, that shows up as a missing or extra strobe, or as a strobe carrying the wrong address or data. A wrong load or shift of the output shift register shows up one byte later, as wrong bits on `miso` during the data byte, or as non-zero bits in a byte that should read back as zero. The bench mixes random writes and read-backs against its own copy of the register contents with directed frames: unknown opcodes, trailing bytes, aborted bytes and the edge addresses.

// File: rtl/spi_reg_cmd_pkg.sv
package spi_reg_cmd_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] OP_WRITE = 8'h01;
  localparam logic [BYTE_W-1:0] OP_READ  = 8'h05;
  localparam logic [BYTE_W-1:0] OP_REVID = 8'h9F;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPC,
    ST_WADDR,
    ST_WDATA,
    ST_RADDR,
    ST_RSTUFF,
    ST_VSTUFF,
    ST_RDATA,
    ST_SKIP
  } cmdState_t;

  // strobes from the frame controller to the datapath
  typedef struct packed {
    logic latchAddr;  // capture the byte just completed as the address
    logic wrStb;      // launch a register write with the byte just completed
    logic rdStb;      // launch a register read
    logic clrHold;    // return value becomes zero
    logic loadRev;    // return value becomes the revision code
    logic armTx;      // load the return value at the next falling SCLK
  } ctrlStb_t;

endpackage

// File: rtl/spi_reg_sync.sv
module spi_reg_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  localparam int TOT_W = W * STAGES;

  logic [TOT_W-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RST_VAL}};
    else       pipe <= {pipe[TOT_W-W-1:0], din};
  end

  assign dout = pipe[TOT_W-1 -: W];

endmodule

// File: rtl/spi_reg_datapath.sv
module spi_reg_datapath
  import spi_reg_cmd_pkg::*;
#(
  parameter logic [BYTE_W-1:0] REV_ID      = 8'h3C,
  parameter logic [BYTE_W-1:0] MAX_ADDR    = 8'h19,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csNIn,
  input  logic              sclkIn,
  input  logic              mosiIn,
  input  ctrlStb_t          strb,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              csIdle,
  output logic              byteDone,
  output logic [BYTE_W-1:0] rxByte,
  output logic              miso,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic [BYTE_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWrData
);

  logic [2:0]        syncOut;
  logic              csS, sclkS, mosiS, sclkQ;
  logic              sclkRise, sclkFall;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxSh;
  logic [BYTE_W-1:0] holdReg;
  logic [BYTE_W-1:0] txSh;
  logic              txArmed;
  logic              rdPend;

  spi_reg_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({csNIn, sclkIn, mosiIn}),
    .dout(syncOut)
  );

  assign csS   = syncOut[2];
  assign sclkS = syncOut[1];
  assign mosiS = syncOut[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkQ <= 1'b0;
    else       sclkQ <= sclkS;
  end

  assign sclkRise = sclkS & ~sclkQ & ~csS;
  assign sclkFall = ~sclkS & sclkQ & ~csS;
  assign csIdle   = csS;

  // receive side
  assign rxByte   = {rxSh[BYTE_W-2:0], mosiS};
  assign byteDone = sclkRise && (bitCnt == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxSh   <= '0;
    end else if (csS) begin
      bitCnt <= '0;
    end else if (sclkRise) begin
      bitCnt <= bitCnt + 1'b1;
      rxSh   <= rxByte;
    end
  end

  // register side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regAddr   <= '0;
      regWrData <= '0;
      regWrEn   <= 1'b0;
      regRdEn   <= 1'b0;
      rdPend    <= 1'b0;
    end else begin
      regWrEn <= strb.wrStb;
      regRdEn <= strb.rdStb;
      rdPend  <= regRdEn;
      if (strb.latchAddr) regAddr   <= rxByte;
      if (strb.wrStb)     regWrData <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              holdReg <= '0;
    else if (strb.clrHold)  holdReg <= '0;
    else if (strb.loadRev)  holdReg <= REV_ID;
    else if (rdPend)        holdReg <= regRdData;
  end

  // transmit side: new bit only after a falling SCLK
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh    <= '0;
      txArmed <= 1'b0;
    end else if (csS) begin
      txSh    <= '0;
      txArmed <= 1'b0;
    end else begin
      if (strb.armTx)   txArmed <= 1'b1;
      else if (sclkFall) txArmed <= 1'b0;
      if (sclkFall) txSh <= txArmed ? holdReg : {txSh[BYTE_W-2:0], 1'b0};
    end
  end

  assign miso = txSh[BYTE_W-1];

  p_wr_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  p_rd_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> !regRdEn);

  p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

  p_addr_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn || regRdEn) |-> (regAddr <= MAX_ADDR));

  p_wr_in_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !$past(csS));

  p_miso_on_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!sclkFall && !csS) |=> $stable(miso));

  p_miso_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> !miso);

endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_cmd_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MAX_ADDR = 8'h19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csIdle,
  input  logic              byteDone,
  input  logic [BYTE_W-1:0] rxByte,
  output ctrlStb_t          strb
);

  cmdState_t state, nextState;
  logic      addrOk;
  logic      rxInRange;

  assign rxInRange = (rxByte <= MAX_ADDR);

  always_comb begin
    nextState = state;
    strb      = '0;
    if (csIdle) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: nextState = ST_OPC;
        ST_OPC: begin
          if (byteDone) begin
            case (rxByte)
              OP_WRITE: nextState = ST_WADDR;
              OP_READ:  nextState = ST_RADDR;
              OP_REVID: begin
                nextState    = ST_VSTUFF;
                strb.loadRev = 1'b1;
              end
              default:  nextState = ST_SKIP;
            endcase
          end
        end
        ST_WADDR: begin
          if (byteDone) begin
            strb.latchAddr = 1'b1;
            nextState      = ST_WDATA;
          end
        end
        ST_WDATA: begin
          if (byteDone) begin
            strb.wrStb = addrOk;
            nextState  = ST_SKIP;
          end
        end
        ST_RADDR: begin
          if (byteDone) begin
            strb.latchAddr = 1'b1;
            strb.rdStb     = rxInRange;
            strb.clrHold   = !rxInRange;
            nextState      = ST_RSTUFF;
          end
        end
        ST_RSTUFF, ST_VSTUFF: begin
          if (byteDone) begin
            strb.armTx = 1'b1;
            nextState  = ST_RDATA;
          end
        end
        ST_RDATA: begin
          if (byteDone) nextState = ST_SKIP;
        end
        default: nextState = ST_SKIP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      addrOk <= 1'b0;
    end else begin
      state <= nextState;
      if (strb.latchAddr) addrOk <= rxInRange;
    end
  end

  p_idle_on_cs_r9: assert property (@(posedge clk) disable iff (!rstN)
    csIdle |=> (state == ST_IDLE));

  p_opcode_first_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |=> (state == ST_IDLE || state == ST_OPC));

  p_skip_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP && !csIdle) |=> (state == ST_SKIP));

  p_skip_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> !(strb.wrStb || strb.rdStb || strb.armTx));

endmodule

// File: rtl/spi_reg_cmd_engine.sv
module spi_reg_cmd_engine
  import spi_reg_cmd_pkg::*;
#(
  parameter logic [7:0] REV_ID      = 8'h3C,
  parameter logic [7:0] MAX_ADDR    = 8'h19,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       mosi,
  output logic       miso,
  output logic       regWrEn,
  output logic       regRdEn,
  output logic [7:0] regAddr,
  output logic [7:0] regWrData,
  input  logic [7:0] regRdData
);

  ctrlStb_t          strb;
  logic              csIdle;
  logic              byteDone;
  logic [BYTE_W-1:0] rxByte;

  spi_reg_datapath #(
    .REV_ID     (REV_ID),
    .MAX_ADDR   (MAX_ADDR),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .csNIn    (csN),
    .sclkIn   (sclk),
    .mosiIn   (mosi),
    .strb     (strb),
    .regRdData(regRdData),
    .csIdle   (csIdle),
    .byteDone (byteDone),
    .rxByte   (rxByte),
    .miso     (miso),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .regWrData(regWrData)
  );

  spi_reg_ctrl #(
    .MAX_ADDR(MAX_ADDR)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csIdle  (csIdle),
    .byteDone(byteDone),
    .rxByte  (rxByte),
    .strb    (strb)
  );

endmodule

// File: tb/spi_reg_cmd_engine_test.sv
`timescale 1ns/1ps
module spi_reg_cmd_engine_test;

  localparam logic [7:0] REV  = 8'hA6;
  localparam int         HALF = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       sclk = 1'b0;
  logic       mosi = 1'b0;
  logic       miso;
  logic       regWrEn, regRdEn;
  logic [7:0] regAddr, regWrData;
  logic [7:0] regRdData;

  int checks = 0;
  int failures = 0;
  int wrCnt = 0;
  int rdCnt = 0;
  logic [7:0] lastWrAddr = '0;
  logic [7:0] lastWrData = '0;
  logic [7:0] mem [0:255];
  logic [7:0] expMem [0:255];
  bit done = 0;

  always #10 clk = ~clk;

  spi_reg_cmd_engine #(.REV_ID(REV)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi), .miso(miso),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  // register bank model: registered read, one clock of latency
  always @(posedge clk) begin
    if (regWrEn) begin
      mem[regAddr] <= regWrData;
      wrCnt        <= wrCnt + 1;
      lastWrAddr   <= regAddr;
      lastWrData   <= regWrData;
    end
    if (regRdEn) begin
      regRdData <= mem[regAddr];
      rdCnt     <= rdCnt + 1;
    end
  end

  function automatic logic [7:0] expRead(input logic [7:0] a);
    return (a <= 8'h19) ? expMem[a] : 8'h00;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic spiBits(input logic [7:0] b, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 0; i < n; i++) begin
      mosi = b[7-i];
      repeat (HALF) @(negedge clk);
      r = {r[6:0], miso};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic csLow();
    @(negedge clk);
    csN = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic csHigh();
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [7:0] d, output logic [7:0] misoOr);
    logic [7:0] r0, r1, r2;
    csLow();
    spiBits(8'h01, 8, r0);
    spiBits(a, 8, r1);
    spiBits(d, 8, r2);
    csHigh();
    misoOr = r0 | r1 | r2;
    if (a <= 8'h19) expMem[a] = d;
  endtask

  task automatic doRead(input logic [7:0] a, input logic [7:0] stuff,
                        output logic [7:0] data, output logic [7:0] misoOr);
    logic [7:0] r0, r1, r2;
    csLow();
    spiBits(8'h05, 8, r0);
    spiBits(a, 8, r1);
    spiBits(stuff, 8, r2);
    spiBits(8'h00, 8, data);
    csHigh();
    misoOr = r0 | r1 | r2;
  endtask

  initial begin
    int wc, rc;
    logic [7:0] d, z, x;
    for (int i = 0; i < 256; i++) begin
      mem[i] = '0;
      expMem[i] = '0;
    end
    regRdData = '0;
    void'($urandom(32'd4242));

    repeat (5) @(negedge clk);
    check("R10 miso in reset", miso, 0);
    check("R10 wr strobe in reset", regWrEn, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 miso after reset", miso, 0);
    check("R10 strobes after reset", {regWrEn, regRdEn}, 0);

    // basic write and read back with an asymmetric value
    wc = wrCnt;
    doWrite(8'h03, 8'hC4, z);
    check("R1 one write strobe", wrCnt - wc, 1);
    check("R1 write address", lastWrAddr, 8'h03);
    check("R1 write data", lastWrData, 8'hC4);
    check("R7 miso zero in write frame", z, 0);
    rc = rdCnt;
    doRead(8'h03, 8'hFF, d, z);
    check("R2 one read strobe", rdCnt - rc, 1);
    check("R4 read data MSB first", d, 8'hC4);
    check("R7 miso zero before data byte", z, 0);

    // stuffing byte value has no effect
    doRead(8'h03, 8'h00, d, z);
    check("R2 read with zero stuffing", d, 8'hC4);

    // revision read with two different don't-care bytes
    rc = rdCnt;
    csLow(); spiBits(8'h9F, 8, z); spiBits(8'h00, 8, x); spiBits(8'h00, 8, d); csHigh();
    check("R3 revision code", d, REV);
    check("R3 no miso before revision", z | x, 0);
    csLow(); spiBits(8'h9F, 8, z); spiBits(8'h5A, 8, x); spiBits(8'hFF, 8, d); csHigh();
    check("R3 revision code other stuffing", d, REV);
    check("R3 no read strobe", rdCnt - rc, 0);

    // boundary addresses
    doWrite(8'h19, 8'h81, z);
    doWrite(8'h00, 8'h7E, z);
    doRead(8'h19, 8'hFF, d, z);
    check("R5 address 0x19 accepted", d, 8'h81);
    doRead(8'h00, 8'hFF, d, z);
    check("R5 address 0x00 accepted", d, 8'h7E);

    // out of range
    wc = wrCnt;
    rc = rdCnt;
    doWrite(8'h1A, 8'h77, z);
    check("R5 no write above range", wrCnt - wc, 0);
    doRead(8'h1A, 8'hFF, d, z);
    check("R5 no read strobe above range", rdCnt - rc, 0);
    check("R5 out-of-range read returns zero", d, 8'h00);
    doRead(8'hF0, 8'hFF, d, z);
    check("R5 far out-of-range read returns zero", d, 8'h00);

    // unknown opcode followed by bytes that look like a command
    wc = wrCnt;
    rc = rdCnt;
    csLow();
    spiBits(8'h02, 8, z);
    spiBits(8'h05, 8, x); z = z | x;
    spiBits(8'h03, 8, x); z = z | x;
    spiBits(8'hFF, 8, x); z = z | x;
    spiBits(8'hFF, 8, x); z = z | x;
    csHigh();
    check("R6 unknown opcode no strobes", (wrCnt - wc) + (rdCnt - rc), 0);
    check("R6 unknown opcode miso zero", z, 0);

    // trailing bytes after a write and after a read
    wc = wrCnt;
    csLow();
    spiBits(8'h01, 8, z); spiBits(8'h04, 8, z); spiBits(8'h5C, 8, z);
    spiBits(8'h01, 8, z); spiBits(8'h07, 8, z); spiBits(8'h33, 8, x);
    csHigh();
    expMem[4] = 8'h5C;
    check("R7 one write despite extra bytes", wrCnt - wc, 1);
    check("R7 first data byte kept", lastWrData, 8'h5C);
    check("R7 extra bytes read as zero", z | x, 0);
    rc = rdCnt;
    csLow();
    spiBits(8'h05, 8, z); spiBits(8'h04, 8, z); spiBits(8'hFF, 8, z);
    spiBits(8'h00, 8, d); spiBits(8'hA5, 8, x);
    csHigh();
    check("R2 read before trailing byte", d, 8'h5C);
    check("R7 byte after read data is zero", x, 0);
    check("R7 one read strobe", rdCnt - rc, 1);

    // aborted data byte
    wc = wrCnt;
    csLow();
    spiBits(8'h01, 8, z); spiBits(8'h06, 8, z); spiBits(8'hEE, 5, z);
    csHigh();
    check("R8 aborted byte gives no write", wrCnt - wc, 0);
    doRead(8'h06, 8'hFF, d, z);
    check("R9 new frame after abort, old value", d, expRead(8'h06));

    // abort in the middle of the opcode, then a full frame
    csLow(); spiBits(8'h05, 3, z); csHigh();
    doWrite(8'h08, 8'h3D, z);
    check("R9 opcode realigned after cs rise", lastWrData, 8'h3D);

    // random write/read-back mix
    for (int n = 0; n < 30; n++) begin
      logic [7:0] a, v, ra;
      a  = 8'($urandom % 26);
      v  = 8'($urandom);
      ra = 8'($urandom % 32);
      doWrite(a, v, z);
      check("R1 random write data", lastWrData, v);
      doRead(ra, 8'($urandom), d, z);
      check("R2 random read back", d, expRead(ra));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule